// File: doc/BRIEF.md
# Hardwired Control Signal Sequencer

This block is the hardwired control unit of a small accumulator machine. A step counter walks through eight timing steps, presented as one-hot lines T0 to T7. Combinational decode combines the current opcode with the active step to produce three groups of control lines for a shared-bus datapath. A read-select group picks which register or memory drives the bus. A write-select group picks which one loads from the bus. An ALU-select group picks add, subtract, clear or idle.

When an instruction's last transfer is done, the decoder raises a counter-reset line. The step counter returns to T0 on the next clock edge and the sequence starts again for the opcode then present. The opcode input is the operation field of the instruction register, which the surrounding datapath holds steady for a whole instruction.

The step register is a state machine with eight named states, `ST_T0` to `ST_T7`. It has two transitions. **ADVANCE** moves from `ST_Tn` to `ST_Tn+1` when counter reset is low, and from `ST_T7` it wraps to `ST_T0`. **RESTART** moves from any state to `ST_T0` when counter reset is high. Reset puts the machine in `ST_T0`.

Top module: `hwseq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the step is T0 (`timing` = 8'h01). Exactly one `timing` bit is high in every cycle.
- R2: If `cnt_rst` is high, the next clock edge selects T0. Otherwise the next edge selects the following step, and T7 wraps to T0.
- R3: Bus addresses are: 0 none, 1 MAR, 2 PC, 3 MBR, 4 AC, 5 memory, 7 IR. `rd_sel[0]`/`[1]`/`[2]` are P0/P1/P2 and `wr_sel[0]`/`[1]`/`[2]` are P3/P4/P5. `alu_sel` is one-hot: bit0 add, bit1 subtract, bit2 clear, bit3 idle (4'b1000).
- R4: LOAD (opcode 4'h1) runs these steps. T0: read IR, write MAR. T1: read memory, write MBR. T2: read MBR, write AC, ALU idle. T3: counter reset.
- R5: STORE (opcode 4'h2) runs these steps. T0: read IR, write MAR. T1: read AC, write MBR. T2: read MBR, write memory. T3: counter reset.
- R6: ADD (opcode 4'h3) runs these steps. T0: read IR, write MAR. T1: read memory, write MBR. T2: read MBR, write AC, ALU add. T3: counter reset.
- R7: SUBT (opcode 4'h4) follows the ADD pattern, except that the ALU selects subtract at T2.
- R8: JUMP (opcode 4'h9) runs these steps. T0: read IR, write PC. T1: counter reset.
- R9: CLEAR (opcode 4'hA) runs these steps. T0: no read, write AC, ALU clear. T1: counter reset.
- R10: For any other opcode, `cnt_rst` is high in every step, both select groups are 0, and the ALU is idle. A known opcode that is present in a step later than its last transfer also raises `cnt_rst`.
- R11: In any cycle where `cnt_rst` is high, `rd_sel` and `wr_sel` are 0 and `alu_sel` is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation field of the held instruction |
| timing | output | 8 | One-hot step lines T0..T7 |
| rd_sel | output | 3 | Bus source address (P2..P0) |
| wr_sel | output | 3 | Bus destination address (P5..P3) |
| alu_sel | output | 4 | One-hot ALU operation |
| cnt_rst | output | 1 | Counter reset, returns the step to T0 |

## Verification
The bench builds the block with its default configuration of a 4-bit opcode, 3-bit bus addresses and eight steps. With that configuration, all sixteen opcodes can be swept. Each opcode runs for ten cycles from reset, so every defined sequence is seen through its counter reset and into its restart. Every undefined opcode is seen restarting at T0 on every edge. Two extra cases cover an asynchronous reset in the middle of an instruction and an opcode change in a step later than the new opcode's last transfer.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = 3;
    localparam int NSTEPS = 8;
    localparam int STEP_W = $clog2(NSTEPS);
    localparam int ALU_W  = 4;

    typedef enum logic [STEP_W-1:0] {
        ST_T0, ST_T1, ST_T2, ST_T3, ST_T4, ST_T5, ST_T6, ST_T7
    } step_e;

    typedef logic [ADDR_W-1:0] busaddr_t;

    localparam busaddr_t BUS_NONE = 3'd0;
    localparam busaddr_t BUS_MAR  = 3'd1;
    localparam busaddr_t BUS_PC   = 3'd2;
    localparam busaddr_t BUS_MBR  = 3'd3;
    localparam busaddr_t BUS_AC   = 3'd4;
    localparam busaddr_t BUS_MEM  = 3'd5;
    localparam busaddr_t BUS_IR   = 3'd7;

    localparam logic [ALU_W-1:0] ALU_ADD  = 4'b0001;
    localparam logic [ALU_W-1:0] ALU_SUB  = 4'b0010;
    localparam logic [ALU_W-1:0] ALU_CLR  = 4'b0100;
    localparam logic [ALU_W-1:0] ALU_IDLE = 4'b1000;

    localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'h3;
    localparam logic [OPC_W-1:0] OP_SUBT  = 4'h4;
    localparam logic [OPC_W-1:0] OP_JUMP  = 4'h9;
    localparam logic [OPC_W-1:0] OP_CLEAR = 4'hA;

    typedef struct packed {
        busaddr_t           rd;
        busaddr_t           wr;
        logic [ALU_W-1:0]   alu;
        logic               cr;
    } ctrl_t;
endpackage

// File: rtl/hwseq_step_ctr.sv
module hwseq_step_ctr
    import hwseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cnt_rst,
    output step_e step
);
    step_e state_q;
    step_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_T0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_T0;
        if (!cnt_rst) begin
            unique case (state_q)
                ST_T0: state_d = ST_T1;
                ST_T1: state_d = ST_T2;
                ST_T2: state_d = ST_T3;
                ST_T3: state_d = ST_T4;
                ST_T4: state_d = ST_T5;
                ST_T5: state_d = ST_T6;
                ST_T6: state_d = ST_T7;
                ST_T7: state_d = ST_T0;
            endcase
        end
    end

    assign step = state_q;
endmodule

// File: rtl/hwseq_timing_dec.sv
module hwseq_timing_dec
    import hwseq_pkg::*;
(
    input  step_e             step,
    output logic [NSTEPS-1:0] timing
);
    for (genvar k = 0; k < NSTEPS; k++) begin : g_tline
        assign timing[k] = (step == step_e'(k));
    end
endmodule

// File: rtl/hwseq_ctrl_dec.sv
module hwseq_ctrl_dec
    import hwseq_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [NSTEPS-1:0] timing,
    output ctrl_t             ctrl
);
    logic is_store;

    assign is_store = (opcode == OP_STORE);

    always_comb begin
        ctrl.rd  = BUS_NONE;
        ctrl.wr  = BUS_NONE;
        ctrl.alu = ALU_IDLE;
        ctrl.cr  = 1'b0;
        case (opcode)
            OP_LOAD, OP_STORE, OP_ADD, OP_SUBT: begin
                if (timing[0]) begin
                    ctrl.rd = BUS_IR;
                    ctrl.wr = BUS_MAR;
                end
                if (timing[1]) begin
                    ctrl.rd = is_store ? BUS_AC : BUS_MEM;
                    ctrl.wr = BUS_MBR;
                end
                if (timing[2]) begin
                    ctrl.rd = BUS_MBR;
                    ctrl.wr = is_store ? BUS_MEM : BUS_AC;
                    if (opcode == OP_ADD)  ctrl.alu = ALU_ADD;
                    if (opcode == OP_SUBT) ctrl.alu = ALU_SUB;
                end
                ctrl.cr = |timing[NSTEPS-1:3];
            end
            OP_JUMP: begin
                if (timing[0]) begin
                    ctrl.rd = BUS_IR;
                    ctrl.wr = BUS_PC;
                end
                ctrl.cr = |timing[NSTEPS-1:1];
            end
            OP_CLEAR: begin
                if (timing[0]) begin
                    ctrl.wr  = BUS_AC;
                    ctrl.alu = ALU_CLR;
                end
                ctrl.cr = |timing[NSTEPS-1:1];
            end
            default: ctrl.cr = 1'b1;
        endcase
    end
endmodule

// File: rtl/hwseq_top.sv
module hwseq_top
    import hwseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    output logic [NSTEPS-1:0] timing,
    output logic [ADDR_W-1:0] rd_sel,
    output logic [ADDR_W-1:0] wr_sel,
    output logic [ALU_W-1:0]  alu_sel,
    output logic              cnt_rst
);
    step_e step;
    ctrl_t ctrl;

    hwseq_step_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_rst (ctrl.cr),
        .step    (step)
    );

    hwseq_timing_dec u_tdec (
        .step   (step),
        .timing (timing)
    );

    hwseq_ctrl_dec u_cdec (
        .opcode (opcode),
        .timing (timing),
        .ctrl   (ctrl)
    );

    assign rd_sel  = ctrl.rd;
    assign wr_sel  = ctrl.wr;
    assign alu_sel = ctrl.alu;
    assign cnt_rst = ctrl.cr;
endmodule

// File: rtl/hwseq_checker.sv
module hwseq_checker
    import hwseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSTEPS-1:0] timing,
    input logic [ADDR_W-1:0] rd_sel,
    input logic [ADDR_W-1:0] wr_sel,
    input logic [ALU_W-1:0]  alu_sel,
    input logic              cnt_rst
);
    a_r1_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(timing) == 1);

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> timing[0]);

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rst && !timing[NSTEPS-1]) |=> (timing == ($past(timing) << 1)));

    a_r3_alu_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alu_sel) == 1);

    a_r11_quiet_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |-> (rd_sel == BUS_NONE && wr_sel == BUS_NONE && alu_sel == ALU_IDLE));

    a_r4_ir_read_at_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == BUS_IR) |-> timing[0]);
endmodule

bind hwseq_top hwseq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .timing  (timing),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel),
    .alu_sel (alu_sel),
    .cnt_rst (cnt_rst)
);

// File: tb/hwseq_top_tb_top.sv
`timescale 1ns/1ps
module hwseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic [7:0] timing;
    logic [2:0] rd_sel;
    logic [2:0] wr_sel;
    logic [3:0] alu_sel;
    logic       cnt_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hwseq_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .timing  (timing),
        .rd_sel  (rd_sel),
        .wr_sel  (wr_sel),
        .alu_sel (alu_sel),
        .cnt_rst (cnt_rst)
    );

    // Expected {rd, wr, alu, cr} per R3 encodings and R4..R10 sequences.
    function automatic logic [10:0] expect_ctrl(input logic [3:0] op, input int s);
        logic [2:0] rd = 3'd0;
        logic [2:0] wr = 3'd0;
        logic [3:0] al = 4'b1000;
        logic       cr = 1'b0;
        case (op)
            4'h1, 4'h2, 4'h3, 4'h4: begin
                if (s == 0) begin rd = 3'd7; wr = 3'd1; end
                else if (s == 1) begin rd = (op == 4'h2) ? 3'd4 : 3'd5; wr = 3'd3; end
                else if (s == 2) begin
                    rd = 3'd3;
                    wr = (op == 4'h2) ? 3'd5 : 3'd4;
                    if (op == 4'h3) al = 4'b0001;
                    if (op == 4'h4) al = 4'b0010;
                end
                else cr = 1'b1;
            end
            4'h9: if (s == 0) begin rd = 3'd7; wr = 3'd2; end else cr = 1'b1;
            4'hA: if (s == 0) begin wr = 3'd4; al = 4'b0100; end else cr = 1'b1;
            default: cr = 1'b1;
        endcase
        return {rd, wr, al, cr};
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'h1: return "R4 LOAD";
            4'h2: return "R5 STORE";
            4'h3: return "R6 ADD";
            4'h4: return "R7 SUBT";
            4'h9: return "R8 JUMP";
            4'hA: return "R9 CLEAR";
            default: return "R10 undefined";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Checks outputs for step s; returns the expected next step (R2).
    task automatic check_step(input int s, output int nxt);
        logic [10:0] e;
        e = expect_ctrl(opcode, s);
        check("R2 timing", {8'h0, timing}, {8'h0, 8'(1 << s)});
        check({"R3 R11 ", op_tag(opcode)}, {5'h0, rd_sel, wr_sel, alu_sel, cnt_rst}, {5'h0, e});
        nxt = e[0] ? 0 : ((s + 1) % 8);
    endtask

    initial begin
        int s;
        int n;
        @(negedge clk);
        #1 check("R1 reset step", {8'h0, timing}, 16'h0001);
        for (int op = 0; op < 16; op++) begin
            rst_n = 1'b0;
            opcode = 4'(op);
            @(negedge clk);
            #1 check("R1 held reset", {8'h0, timing}, 16'h0001);
            rst_n = 1'b1;
            s = 0;
            for (int c = 0; c < 10; c++) begin
                #1 check_step(s, n);
                s = n;
                @(negedge clk);
            end
        end
        // R1: asynchronous reset in mid-instruction
        rst_n = 1'b0; opcode = 4'h3;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 check("R1 mid step", {8'h0, timing}, 16'h0004);
        rst_n = 1'b0;
        #1 check("R1 async reset", {8'h0, timing}, 16'h0001);
        @(negedge clk); rst_n = 1'b1;
        // R10: opcode changed to JUMP while at T2 of ADD
        @(negedge clk); @(negedge clk);
        opcode = 4'h9;
        #1 check_step(2, n);
        check("R10 late step restart", {15'h0, cnt_rst}, 16'h0001);
        @(negedge clk);
        #1 check_step(n, n);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule